// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbiter

This block is a 1024-word by 8-bit memory with two fully independent access ports, called left and right. Each port has its own address, write data, read data, a read-data-valid flag, a chip enable, a write enable and an output enable. When both enabled ports point at the same word, an arbiter gives that word to whichever port got there first. It tells the other port through an active-low busy output.

The losing port's write is dropped. Its read still goes ahead, and the busy output warns that the data may be stale. Ownership stays with the winner while the clash lasts.

One clock models the asynchronous timing. A port has arrived at a location when its address and enable are unchanged from the previous cycle. A mode input turns the device into a slave for width stacking. In slave mode the local arbiter no longer drives the busy outputs, and two busy inputs from the single master of the group suppress the local writes.

Top module: `dp_arb_ram`

## Requirements
- R1: A port writes dinX to location addrX on the clock edge when ceX=1 and weX=1, unless that write is inhibited. If either enable is 0, nothing is written.
- R2: When ceX=1, weX=0 and oeX=1 in a cycle, doutX holds the word at addrX one cycle later and doutValidX=1. Otherwise, one cycle later doutValidX=0 and doutX=0.
- R3: A clash exists only when ceL=1, ceR=1 and addrL equals addrR. Without a clash, busyLN=1 and busyRN=1 in that same cycle. A mismatched address or a dropped enable frees the busy output at once.
- R4: At the first clashing cycle, a port whose address and enable are unchanged from the previous cycle wins over a port that has just changed. The loser's busy output is 0, and the winner's is 1.
- R5: If neither port, or both, arrived earlier at the first clashing cycle, the left port wins, so busyRN=0 and busyLN=1.
- R6: The winner keeps ownership for as long as the clash lasts, whatever either port does with its write or output enables. A new arbitration starts only after a cycle without a clash.
- R7: When both clashing ports read, both reads return valid data, and the loser still sees busy.
- R8: A write from the losing port is inhibited, and the word keeps its value. This holds whether the winner reads or writes.
- R9: When the winner writes and the loser reads the same word in the same cycle, the write completes. The loser's read returns the word's value from before that edge.
- R10: With slaveMode=1, busyLN and busyRN stay 1. A 0 on extBusyLN or extBusyRN inhibits that port's write, and the local arbitration inhibits nothing. With slaveMode=0, the busy inputs are ignored.
- R11: While rstN=0, doutL, doutR, doutValidL and doutValidR are 0 and arbitration state is cleared. The memory array is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slaveMode | input | 1 | 1 = slave: busy comes from external inputs |
| addrL | input | 10 | Left address |
| dinL | input | 8 | Left write data |
| ceL | input | 1 | Left chip enable, active high |
| weL | input | 1 | Left write enable, active high |
| oeL | input | 1 | Left output enable, active high |
| extBusyLN | input | 1 | Left busy from the master, active low (slave mode) |
| doutL | output | 8 | Left read data |
| doutValidL | output | 1 | Left read data valid |
| busyLN | output | 1 | Left lost arbitration, active low |
| addrR | input | 10 | Right address |
| dinR | input | 8 | Right write data |
| ceR | input | 1 | Right chip enable, active high |
| weR | input | 1 | Right write enable, active high |
| oeR | input | 1 | Right output enable, active high |
| extBusyRN | input | 1 | Right busy from the master, active low (slave mode) |
| doutR | output | 8 | Right read data |
| doutValidR | output | 1 | Right read data valid |
| busyRN | output | 1 | Right lost arbitration, active low |

## Verification
The two functions that can fall in the same cycle are a completed write by the winning port and a read of the same word by the losing port. They also meet a write by the loser that must be dropped while the winner reads it. Directed sequences hold both ports on one word and toggle their write enables. Random traffic confined to four addresses, with sticky address choices, provokes the same collisions many times. A bench reference model judges each cycle: it predicts the busy outputs from arrival order and the read data from the memory contents before the edge, then applies only the writes that are not inhibited.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrL;
    logic wrR;
    logic rdL;
    logic rdR;
  } strobe_t;
endpackage

// File: rtl/dp_arb_ctrl.sv
module dp_arb_ctrl
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              ceL,
  input  logic              weL,
  input  logic              oeL,
  input  logic              extBusyLN,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              ceR,
  input  logic              weR,
  input  logic              oeR,
  input  logic              extBusyRN,
  output logic              busyLN,
  output logic              busyRN,
  output strobe_t           strobe
);
  logic [ADDR_W-1:0] prevAddrL, prevAddrR;
  logic              prevCeL, prevCeR;
  owner_e            ownerQ, winner;
  logic              match, steadyL, steadyR;
  logic              loseL, loseR, inhibitL, inhibitR;

  assign match   = ceL && ceR && (addrL == addrR);
  assign steadyL = prevCeL && ceL && (addrL == prevAddrL);
  assign steadyR = prevCeR && ceR && (addrR == prevAddrR);

  always_comb begin
    winner = OWN_NONE;
    if (match) begin
      if (ownerQ != OWN_NONE)       winner = ownerQ;
      else if (steadyR && !steadyL) winner = OWN_RIGHT;
      else                          winner = OWN_LEFT;
    end
  end

  assign loseL = (winner == OWN_RIGHT);
  assign loseR = (winner == OWN_LEFT);

  assign inhibitL = slaveMode ? !extBusyLN : loseL;
  assign inhibitR = slaveMode ? !extBusyRN : loseR;

  assign busyLN = !(loseL && !slaveMode);
  assign busyRN = !(loseR && !slaveMode);

  always_comb begin
    strobe.wrL = ceL && weL && !inhibitL;
    strobe.wrR = ceR && weR && !inhibitR;
    strobe.rdL = ceL && !weL && oeL;
    strobe.rdR = ceR && !weR && oeR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ    <= OWN_NONE;
      prevAddrL <= '0;
      prevAddrR <= '0;
      prevCeL   <= 1'b0;
      prevCeR   <= 1'b0;
    end else begin
      ownerQ    <= winner;
      prevAddrL <= addrL;
      prevAddrR <= addrR;
      prevCeL   <= ceL;
      prevCeR   <= ceR;
    end
  end
endmodule

// File: rtl/dp_arb_mem.sv
module dp_arb_mem
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] dinL,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] dinR,
  output logic [DATA_W-1:0] doutL,
  output logic              doutValidL,
  output logic [DATA_W-1:0] doutR,
  output logic              doutValidR
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPORT = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdAddr [NPORT];
  logic              rdEn   [NPORT];
  logic [DATA_W-1:0] rdData [NPORT];
  logic              rdVld  [NPORT];

  assign rdAddr[0] = addrL;
  assign rdAddr[1] = addrR;
  assign rdEn[0]   = strobe.rdL;
  assign rdEn[1]   = strobe.rdR;

  // right write follows left: only reachable in slave mode
  always_ff @(posedge clk) begin
    if (strobe.wrL) mem[addrL] <= dinL;
    if (strobe.wrR) mem[addrR] <= dinR;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData[p] <= '0;
        rdVld[p]  <= 1'b0;
      end else begin
        rdData[p] <= rdEn[p] ? mem[rdAddr[p]] : '0;
        rdVld[p]  <= rdEn[p];
      end
    end
  end

  assign doutL      = rdData[0];
  assign doutValidL = rdVld[0];
  assign doutR      = rdData[1];
  assign doutValidR = rdVld[1];
endmodule

// File: rtl/dp_arb_ram.sv
module dp_arb_ram
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] dinL,
  input  logic              ceL,
  input  logic              weL,
  input  logic              oeL,
  input  logic              extBusyLN,
  output logic [DATA_W-1:0] doutL,
  output logic              doutValidL,
  output logic              busyLN,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] dinR,
  input  logic              ceR,
  input  logic              weR,
  input  logic              oeR,
  input  logic              extBusyRN,
  output logic [DATA_W-1:0] doutR,
  output logic              doutValidR,
  output logic              busyRN
);
  strobe_t strobe;

  dp_arb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .addrL(addrL), .ceL(ceL), .weL(weL), .oeL(oeL), .extBusyLN(extBusyLN),
    .addrR(addrR), .ceR(ceR), .weR(weR), .oeR(oeR), .extBusyRN(extBusyRN),
    .busyLN(busyLN), .busyRN(busyRN), .strobe(strobe)
  );

  dp_arb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .addrL(addrL), .dinL(dinL), .addrR(addrR), .dinR(dinR),
    .doutL(doutL), .doutValidL(doutValidL),
    .doutR(doutR), .doutValidR(doutValidR)
  );
endmodule

// File: rtl/dp_arb_chk.sv
module dp_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              slaveMode,
  input logic [ADDR_W-1:0] addrL,
  input logic              ceL,
  input logic              weL,
  input logic              oeL,
  input logic              doutValidL,
  input logic              busyLN,
  input logic [ADDR_W-1:0] addrR,
  input logic              ceR,
  input logic              weR,
  input logic              oeR,
  input logic              doutValidR,
  input logic              busyRN
);
  logic armed;
  logic clash;

  assign clash = ceL && ceR && (addrL == addrR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_no_clash_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    !clash |-> (busyLN && busyRN));

  assert_single_loser_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyLN && !busyRN));

  assert_owner_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && clash && $past(clash) && !slaveMode && $past(!slaveMode))
      |-> (busyLN == $past(busyLN) && busyRN == $past(busyRN)));

  assert_read_valid_left_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (doutValidL == $past(ceL && !weL && oeL)));

  assert_read_valid_right_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (doutValidR == $past(ceR && !weR && oeR)));

  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> (busyLN && busyRN));
endmodule

bind dp_arb_ram dp_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
  .addrL(addrL), .ceL(ceL), .weL(weL), .oeL(oeL),
  .doutValidL(doutValidL), .busyLN(busyLN),
  .addrR(addrR), .ceR(ceR), .weR(weR), .oeR(oeR),
  .doutValidR(doutValidR), .busyRN(busyRN)
);

// File: tb/sim_dp_arb_ram.sv
`timescale 1ns/1ps
module sim_dp_arb_ram;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slaveMode = 1'b0;
  logic [9:0] addrL = '0, addrR = '0;
  logic [7:0] dinL = '0, dinR = '0;
  logic       ceL = 0, weL = 0, oeL = 0, ceR = 0, weR = 0, oeR = 0;
  logic       extBusyLN = 1'b1, extBusyRN = 1'b1;
  logic [7:0] doutL, doutR;
  logic       doutValidL, doutValidR, busyLN, busyRN;

  always #4 clk = ~clk;

  dp_arb_ram u0 (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .addrL(addrL), .dinL(dinL), .ceL(ceL), .weL(weL), .oeL(oeL),
    .extBusyLN(extBusyLN), .doutL(doutL), .doutValidL(doutValidL), .busyLN(busyLN),
    .addrR(addrR), .dinR(dinR), .ceR(ceR), .weR(weR), .oeR(oeR),
    .extBusyRN(extBusyRN), .doutR(doutR), .doutValidR(doutValidR), .busyRN(busyRN)
  );

  int nRun = 0, nFail = 0;

  // reference model
  logic [7:0] mMem [0:1023];
  int         mOwn = 0;
  logic [9:0] mPaL = '0, mPaR = '0;
  logic       mPcL = 0, mPcR = 0;
  logic [7:0] mDoL = '0, mDoR = '0;
  logic       mVL = 0, mVR = 0;
  int         cWin = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] pickAddr();
    case ($urandom % 4)
      0: return 10'd0;
      1: return 10'd1;
      2: return 10'd2;
      default: return 10'd1023;
    endcase
  endfunction

  // entered just after a rising edge; leaves at mid cycle
  task automatic look();
    logic clash, stL, stR;
    #3;
    clash = ceL && ceR && (addrL == addrR);
    stL = mPcL && ceL && (addrL == mPaL);
    stR = mPcR && ceR && (addrR == mPaR);
    cWin = 0;
    if (clash) cWin = (mOwn != 0) ? mOwn : ((stR && !stL) ? 2 : 1);
    chk("R4 busy left", busyLN, !(!slaveMode && cWin == 2));
    chk("R4 busy right", busyRN, !(!slaveMode && cWin == 1));
    chk("R2 valid left", doutValidL, mVL);
    chk("R2 data left", doutL, mDoL);
    chk("R2 valid right", doutValidR, mVR);
    chk("R2 data right", doutR, mDoR);
  endtask

  task automatic tick();
    logic inL, inR, wL, wR, nvL, nvR;
    logic [7:0] nL, nR;
    inL = slaveMode ? !extBusyLN : (cWin == 2);
    inR = slaveMode ? !extBusyRN : (cWin == 1);
    wL  = ceL && weL && !inL;
    wR  = ceR && weR && !inR;
    nvL = ceL && !weL && oeL;
    nvR = ceR && !weR && oeR;
    nL  = nvL ? mMem[addrL] : 8'h00;
    nR  = nvR ? mMem[addrR] : 8'h00;
    @(posedge clk);
    if (wL) mMem[addrL] = dinL;
    if (wR) mMem[addrR] = dinR;
    mDoL = nL; mVL = nvL; mDoR = nR; mVR = nvR;
    mOwn = cWin;
    mPaL = addrL; mPcL = ceL; mPaR = addrR; mPcR = ceR;
    #1;
  endtask

  task automatic cycle();
    look();
    tick();
  endtask

  task automatic setL(input logic c, input logic w, input logic o,
                      input logic [9:0] a, input logic [7:0] d);
    ceL = c; weL = w; oeL = o; addrL = a; dinL = d;
  endtask

  task automatic setR(input logic c, input logic w, input logic o,
                      input logic [9:0] a, input logic [7:0] d);
    ceR = c; weR = w; oeR = o; addrR = a; dinR = d;
  endtask

  initial begin
    #(200000 * 8);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [9:0] pre [4];
    logic [7:0] val [4];
    void'($urandom(32'd20240611));
    pre[0] = 10'd0;    val[0] = 8'h11;
    pre[1] = 10'd1;    val[1] = 8'h22;
    pre[2] = 10'd2;    val[2] = 8'h33;
    pre[3] = 10'd1023; val[3] = 8'hA5;

    repeat (3) @(posedge clk);
    #3;
    chk("R11 reset busy left", busyLN, 1);
    chk("R11 reset busy right", busyRN, 1);
    chk("R11 reset valid left", doutValidL, 0);
    chk("R11 reset valid right", doutValidR, 0);
    chk("R11 reset data left", doutL, 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    // R1: preload through the left port, read back through the right
    for (int i = 0; i < 4; i++) begin
      setL(1, 1, 0, pre[i], val[i]);
      cycle();
    end
    setL(0, 0, 0, 10'd0, 8'h00);
    setR(1, 0, 1, 10'd1023, 8'h00);
    cycle();
    setR(0, 0, 0, 10'd0, 8'h00);
    look();
    chk("R1 written word read back", doutR, 8'hA5);
    tick();
    // R1: enable off means no write
    setL(0, 1, 0, 10'd0, 8'hEE);
    cycle();
    setL(1, 0, 1, 10'd0, 8'h00);
    cycle();
    setL(0, 0, 0, 10'd0, 8'h00);
    look();
    chk("R1 no write without chip enable", doutL, 8'h11);
    tick();

    // R5: simultaneous arrival, left wins
    setL(1, 0, 1, 10'd2, 8'h00);
    setR(1, 0, 1, 10'd2, 8'h00);
    look();
    chk("R5 tie right busy", busyRN, 0);
    chk("R5 tie left free", busyLN, 1);
    tick();
    // R7: both reads valid
    look();
    chk("R7 left read valid", doutValidL, 1);
    chk("R7 left data", doutL, 8'h33);
    chk("R7 right read valid despite busy", doutR, 8'h33);
    tick();
    // R6, R9: winner writes, loser reads
    setL(1, 1, 1, 10'd2, 8'h77);
    look();
    chk("R6 ownership held", busyRN, 0);
    tick();
    // R8: loser writes, winner reads
    setL(1, 0, 1, 10'd2, 8'h00);
    setR(1, 1, 0, 10'd2, 8'h99);
    look();
    chk("R9 loser reads old word", doutR, 8'h33);
    chk("R8 loser busy while writing", busyRN, 0);
    tick();
    setR(0, 0, 0, 10'd0, 8'h00);
    cycle();
    setL(0, 0, 0, 10'd0, 8'h00);
    look();
    chk("R8 loser write inhibited", doutL, 8'h77);
    tick();

    // R4: left first
    setL(1, 0, 1, 10'd1, 8'h00);
    cycle();
    setR(1, 0, 1, 10'd1, 8'h00);
    look();
    chk("R4 left first right busy", busyRN, 0);
    chk("R4 left first left free", busyLN, 1);
    tick();
    // R3: mismatch frees at once
    setR(1, 0, 1, 10'd0, 8'h00);
    look();
    chk("R3 mismatch frees right", busyRN, 1);
    tick();
    // R4: right first
    setL(1, 0, 1, 10'd0, 8'h00);
    look();
    chk("R4 right first left busy", busyLN, 0);
    chk("R4 right first right free", busyRN, 1);
    tick();
    // R3: enable drop frees
    setR(0, 0, 1, 10'd0, 8'h00);
    look();
    chk("R3 enable drop frees left", busyLN, 1);
    tick();
    // R6: rearbitration after a break, left now first
    setR(1, 0, 1, 10'd0, 8'h00);
    look();
    chk("R6 fresh arbitration after break", busyRN, 0);
    tick();
    setL(0, 0, 0, 10'd0, 8'h00);
    setR(0, 0, 0, 10'd0, 8'h00);
    cycle();

    // R10: slave mode
    slaveMode = 1'b1;
    extBusyLN = 1'b0;
    setL(1, 1, 0, 10'd1, 8'h3C);
    setR(1, 1, 0, 10'd2, 8'h5A);
    look();
    chk("R10 slave busy left high", busyLN, 1);
    chk("R10 slave busy right high", busyRN, 1);
    tick();
    extBusyLN = 1'b1;
    setL(1, 0, 1, 10'd2, 8'h00);
    setR(1, 0, 1, 10'd2, 8'h00);
    look();
    chk("R10 slave ignores own clash", busyRN, 1);
    tick();
    setL(1, 0, 1, 10'd1, 8'h00);
    setR(0, 0, 0, 10'd0, 8'h00);
    look();
    chk("R10 unblocked slave write landed", doutL, 8'h5A);
    tick();
    setL(0, 0, 0, 10'd0, 8'h00);
    look();
    chk("R10 external busy inhibits write", doutL, 8'h22);
    tick();
    slaveMode = 1'b0;
    cycle();

    // random traffic, master mode, busy inputs toggling and ignored
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 2) addrL = pickAddr();
      if ($urandom % 2) addrR = pickAddr();
      ceL = ($urandom % 5) != 0;
      ceR = ($urandom % 5) != 0;
      weL = ($urandom % 5) < 2;
      weR = ($urandom % 5) < 2;
      oeL = ($urandom % 5) != 0;
      oeR = ($urandom % 5) != 0;
      dinL = 8'($urandom);
      dinR = 8'($urandom);
      extBusyLN = 1'($urandom);
      extBusyRN = 1'($urandom);
      cycle();
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule